// File: doc/BRIEF.md
# ADC DMA Request and Overrun Manager

This block sits between the result register of an analog-to-digital converter and a DMA engine. Each conversion that completes while DMA service is switched on raises a level request that stays up until the DMA engine acknowledges it. An acknowledge marks the held result as taken. A conversion that completes while the previous result is still untaken is an overrun. On an overrun the block sets a sticky flag and stops requesting until software clears the flag with a write-1 pulse. A policy input selects whether the held result survives the overrun or is replaced by the newer sample.

Two transfer modes are supported. In circular mode the DMA end-of-transfer indication has no effect and requests continue. In one-shot mode the end-of-transfer indication freezes the data register, discards any conversion that lands in the same cycle or later, stops requests, and sends a one-cycle abort command to the sequencer so that the scan restarts from its first entry. The stopped state ends on a start command, or on an accepted configuration write that changes the DMA enable bit. Configuration writes take effect only while no conversion is running.

Top module: `adc_dma_ovr_mgr`

## Requirements
- R1: With DMA on and no overrun pending, a `conv_done_i` pulse loads `conv_data_i` into `data_o` and raises `dma_req_o`, both visible one cycle after the pulse.
- R2: `dma_req_o` stays high until `dma_ack_i` is seen. An acknowledge with no conversion in the same cycle drops the request in the next cycle.
- R3: A conversion that completes while `dma_req_o` is high and `dma_ack_i` is low sets `ovr_flag_o` and drops `dma_req_o` in the next cycle. No request is raised while the flag is set.
- R4: `ovr_keep_i`=1 makes `data_o` keep its value on the overrunning conversion and on every conversion while the flag is set. `ovr_keep_i`=0 loads the new sample in both cases.
- R5: An `ovr_clr_i` pulse clears `ovr_flag_o` in the next cycle. An overrun in the same cycle as the clear leaves the flag set.
- R6: With `cfg_circ_i`=0 (one-shot) and DMA on, a `dma_eot_i` pulse does the following in the next cycle: it raises `seq_abort_o` for exactly one cycle, drops `dma_req_o`, and freezes `data_o`. A conversion in the same cycle as the pulse, or in any later cycle while stopped, changes no output and raises no overrun.
- R7: The stopped state ends after a cycle with `start_i`=1, or after an accepted configuration write whose `cfg_dma_en_i` differs from the current enable. Conversions after that are served normally.
- R8: With `cfg_circ_i`=1 (circular), `dma_eot_i` produces no abort and has no effect on requests or data.
- R9: A `cfg_we_i` pulse loads `cfg_dma_en_i` and `cfg_circ_i` only if `conv_busy_i` is low. Otherwise the write is ignored.
- R10: A conversion and an acknowledge in the same cycle raise no overrun. The acknowledge consumes the old result and the request stays high for the new one.
- R11: With DMA off, conversions still load `data_o` but raise no request and no overrun. An accepted write that turns DMA off drops a pending request in the next cycle.
- R12: After reset, `dma_req_o`, `ovr_flag_o` and `seq_abort_o` are low and `data_o` is zero. DMA is off and the mode is one-shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | One-cycle pulse: a channel conversion completed |
| conv_data_i | input | DATA_W | Result of the completing conversion |
| conv_busy_i | input | 1 | A regular or injected conversion is running |
| start_i | input | 1 | Start command, releases the one-shot stopped state |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_dma_en_i | input | 1 | DMA enable value to write |
| cfg_circ_i | input | 1 | Mode value to write: 0 one-shot, 1 circular |
| ovr_keep_i | input | 1 | Overrun policy: 1 keep old data, 0 overwrite |
| ovr_clr_i | input | 1 | Write-1 pulse that clears the overrun flag |
| dma_ack_i | input | 1 | DMA acknowledge of the pending request |
| dma_eot_i | input | 1 | DMA end-of-transfer pulse |
| dma_req_o | output | 1 | DMA request, held until acknowledged |
| ovr_flag_o | output | 1 | Sticky overrun flag |
| seq_abort_o | output | 1 | One-cycle abort and reset command to the sequencer |
| data_o | output | DATA_W | Data register |

## Verification
Three pairs of events can fall in the same cycle. An acknowledge can arrive together with the next conversion done. An overrun can coincide with the software clear of the flag. A one-shot end-of-transfer can land on the same edge as a conversion done. The bench drives each of these pairs on purpose in directed steps. It then checks one cycle later that the request survives without an overrun, that the flag stays set, and that the late sample is discarded. A long stretch of random stimulus then produces further such collisions, and a behavioural reference model judges every cycle of it.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_CIRC    = 1'b1
  } dma_mode_e;

  typedef struct packed {
    logic      dma_en;
    dma_mode_e mode;
  } dma_cfg_t;

  localparam dma_cfg_t CFG_RST = '{dma_en: 1'b0, mode: MODE_ONESHOT};
endpackage

// File: rtl/adc_dma_cfg.sv
module adc_dma_cfg
  import adc_dma_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  logic     busy_i,
  input  logic     en_i,
  input  logic     circ_i,
  output dma_cfg_t cfg_o,
  output logic     en_next_o,
  output logic     en_toggle_o
);
  dma_cfg_t cfg_q;
  logic     wr_ok;

  // writes land only while the converter is idle
  assign wr_ok = we_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else if (wr_ok) begin
      cfg_q.dma_en <= en_i;
      cfg_q.mode   <= dma_mode_e'(circ_i);
    end
  end

  assign cfg_o       = cfg_q;
  assign en_next_o   = wr_ok ? en_i : cfg_q.dma_en;
  assign en_toggle_o = wr_ok & (en_i != cfg_q.dma_en);
endmodule

// File: rtl/adc_dma_flow.sv
module adc_dma_flow
  import adc_dma_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     conv_done_i,
  input  logic     dma_ack_i,
  input  logic     dma_eot_i,
  input  logic     start_i,
  input  dma_cfg_t cfg_i,
  input  logic     en_next_i,
  input  logic     en_toggle_i,
  input  logic     ovr_flag_i,
  output logic     req_o,
  output logic     abort_o,
  output logic     live_o,
  output logic     ovr_evt_o
);
  logic req_q, req_d;
  logic stop_q, abort_q;
  logic stop_evt, accept;

  assign stop_evt  = dma_eot_i & cfg_i.dma_en & (cfg_i.mode == MODE_ONESHOT) & ~stop_q;
  assign live_o    = conv_done_i & ~stop_q & ~stop_evt;
  assign ovr_evt_o = live_o & req_q & ~dma_ack_i;
  assign accept    = live_o & ~ovr_evt_o & cfg_i.dma_en & ~ovr_flag_i;

  always_comb begin
    req_d = req_q;
    if (stop_evt)       req_d = 1'b0;
    else if (accept)    req_d = 1'b1;
    else if (ovr_evt_o) req_d = 1'b0;
    else if (dma_ack_i) req_d = 1'b0;
    if (!en_next_i)     req_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      stop_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      req_q   <= req_d;
      abort_q <= stop_evt;
      if (stop_evt)                            stop_q <= 1'b1;
      else if (stop_q & (start_i | en_toggle_i)) stop_q <= 1'b0;
    end
  end

  assign req_o   = req_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/adc_dma_ovr.sv
module adc_dma_ovr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovr_evt_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // a new overrun outranks the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (ovr_evt_i) flag_q <= 1'b1;
    else if (clr_i)     flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/adc_dma_dreg.sv
module adc_dma_dreg #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              live_i,
  input  logic              ovr_evt_i,
  input  logic              ovr_flag_i,
  input  logic              keep_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] data_q;
  logic              hold;

  assign hold = (ovr_evt_i | ovr_flag_i) & keep_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              data_q <= '0;
    else if (live_i && !hold) data_q <= din_i;
  end

  assign dout_o = data_q;
endmodule

// File: rtl/adc_dma_ovr_mgr.sv
module adc_dma_ovr_mgr
  import adc_dma_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic              conv_busy_i,
  input  logic              start_i,
  input  logic              cfg_we_i,
  input  logic              cfg_dma_en_i,
  input  logic              cfg_circ_i,
  input  logic              ovr_keep_i,
  input  logic              ovr_clr_i,
  input  logic              dma_ack_i,
  input  logic              dma_eot_i,
  output logic              dma_req_o,
  output logic              ovr_flag_o,
  output logic              seq_abort_o,
  output logic [DATA_W-1:0] data_o
);
  dma_cfg_t cfg;
  logic     en_next, en_toggle, live, ovr_evt, ovr_flag;

  adc_dma_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .busy_i      (conv_busy_i),
    .en_i        (cfg_dma_en_i),
    .circ_i      (cfg_circ_i),
    .cfg_o       (cfg),
    .en_next_o   (en_next),
    .en_toggle_o (en_toggle)
  );

  adc_dma_flow u_flow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_done_i (conv_done_i),
    .dma_ack_i   (dma_ack_i),
    .dma_eot_i   (dma_eot_i),
    .start_i     (start_i),
    .cfg_i       (cfg),
    .en_next_i   (en_next),
    .en_toggle_i (en_toggle),
    .ovr_flag_i  (ovr_flag),
    .req_o       (dma_req_o),
    .abort_o     (seq_abort_o),
    .live_o      (live),
    .ovr_evt_o   (ovr_evt)
  );

  adc_dma_ovr u_ovr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovr_evt_i (ovr_evt),
    .clr_i     (ovr_clr_i),
    .flag_o    (ovr_flag)
  );

  adc_dma_dreg #(.DATA_W(DATA_W)) u_dreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .live_i     (live),
    .ovr_evt_i  (ovr_evt),
    .ovr_flag_i (ovr_flag),
    .keep_i     (ovr_keep_i),
    .din_i      (conv_data_i),
    .dout_o     (data_o)
  );

  assign ovr_flag_o = ovr_flag;
endmodule

// File: rtl/adc_dma_ovr_mgr_chk.sv
module adc_dma_ovr_mgr_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              conv_done_i,
  input logic              cfg_we_i,
  input logic              ovr_keep_i,
  input logic              ovr_clr_i,
  input logic              dma_ack_i,
  input logic              dma_eot_i,
  input logic              dma_req_o,
  input logic              ovr_flag_o,
  input logic              seq_abort_o,
  input logic [DATA_W-1:0] data_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o && !dma_ack_i && !dma_eot_i && !conv_done_i && !cfg_we_i |=> dma_req_o); // R2
  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o && dma_ack_i && !conv_done_i |=> !dma_req_o); // R2
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i && dma_req_o && !dma_ack_i && !dma_eot_i |=> ovr_flag_o); // R3
  AST_NO_REQ_IN_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_flag_o |-> !dma_req_o); // R3
  AST_KEEP_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i && ovr_flag_o && ovr_keep_i |=> $stable(data_o)); // R4
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_flag_o && !ovr_clr_i |=> ovr_flag_o); // R5
  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_abort_o |=> !seq_abort_o); // R6
  AST_ABORT_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_abort_o |-> !dma_req_o); // R6
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_abort_o |=> $stable(data_o)); // R6
endmodule

bind adc_dma_ovr_mgr adc_dma_ovr_mgr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_done_i (conv_done_i),
  .cfg_we_i    (cfg_we_i),
  .ovr_keep_i  (ovr_keep_i),
  .ovr_clr_i   (ovr_clr_i),
  .dma_ack_i   (dma_ack_i),
  .dma_eot_i   (dma_eot_i),
  .dma_req_o   (dma_req_o),
  .ovr_flag_o  (ovr_flag_o),
  .seq_abort_o (seq_abort_o),
  .data_o      (data_o)
);

// File: tb/adc_dma_ovr_mgr_bench.sv
`timescale 1ns/1ps
module adc_dma_ovr_mgr_bench;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv_done = 0, conv_busy = 0, start = 0, cfg_we = 0;
  logic          cfg_en = 0, cfg_circ = 0, keep = 0, clr = 0, ack = 0, eot = 0;
  logic [DW-1:0] conv_data = '0;
  logic          req, ovr, abort_o;
  logic [DW-1:0] data;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  adc_dma_ovr_mgr #(.DATA_W(DW)) u_adc_dma_ovr_mgr (
    .clk_i(clk), .rst_ni(rst_n), .conv_done_i(conv_done), .conv_data_i(conv_data),
    .conv_busy_i(conv_busy), .start_i(start), .cfg_we_i(cfg_we), .cfg_dma_en_i(cfg_en),
    .cfg_circ_i(cfg_circ), .ovr_keep_i(keep), .ovr_clr_i(clr), .dma_ack_i(ack),
    .dma_eot_i(eot), .dma_req_o(req), .ovr_flag_o(ovr), .seq_abort_o(abort_o), .data_o(data)
  );

  // behavioural reference model
  int m_req, m_ovr, m_stop, m_abort, m_en, m_circ;
  int m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 0; m_ovr = 0; m_stop = 0; m_abort = 0; m_en = 0; m_circ = 0; m_data = 0;
    end else begin
      int ne, nc, tog, stopev, act, ovrev, accept;
      ne = m_en; nc = m_circ; tog = 0;
      if (cfg_we && !conv_busy) begin
        ne = cfg_en; nc = cfg_circ; tog = (cfg_en != m_en);
      end
      stopev = eot && m_en && !m_circ && !m_stop;
      act    = conv_done && !m_stop && !stopev;
      ovrev  = act && m_req && !ack;
      accept = act && !ovrev && m_en && !m_ovr;
      if (act && !((ovrev || m_ovr) && keep)) m_data = int'(conv_data);
      if (stopev) m_req = 0;
      else if (accept) m_req = 1;
      else if (ovrev || ack) m_req = 0;
      if (!ne) m_req = 0;
      if (ovrev) m_ovr = 1; else if (clr) m_ovr = 0;
      if (stopev) m_stop = 1; else if (m_stop && (start || tog)) m_stop = 0;
      m_abort = stopev;
      m_en = ne; m_circ = nc;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("model(all) req", int'(req), m_req);
      chk("model(all) ovr", int'(ovr), m_ovr);
      chk("model(all) abort", int'(abort_o), m_abort);
      chk("model(all) data", int'(data), m_data);
    end
  end

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic conv(input logic [DW-1:0] d);
    conv_done = 1; conv_data = d; cyc(); conv_done = 0;
  endtask

  task automatic wcfg(input logic en, input logic circ);
    cfg_we = 1; cfg_en = en; cfg_circ = circ; cyc(); cfg_we = 0;
  endtask

  task automatic do_ack();
    ack = 1; cyc(); ack = 0;
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 req", int'(req), 0);
    chk("R12 ovr", int'(ovr), 0);
    chk("R12 abort", int'(abort_o), 0);
    chk("R12 data", int'(data), 0);

    conv(16'h0011);
    chk("R11 data loads with DMA off", int'(data), 'h11);
    chk("R11 no req", int'(req), 0);
    conv(16'h0022);
    chk("R11 no overrun", int'(ovr), 0);

    conv_busy = 1; wcfg(1, 0); conv_busy = 0;
    conv(16'h0033);
    chk("R9 write while busy ignored", int'(req), 0);
    wcfg(1, 0);

    conv(16'h0044);
    chk("R1 req", int'(req), 1);
    chk("R1 data", int'(data), 'h44);
    cyc(); cyc(); cyc();
    chk("R2 req held", int'(req), 1);
    do_ack();
    chk("R2 ack drops req", int'(req), 0);

    conv(16'h0055);
    conv_done = 1; conv_data = 16'h0066; ack = 1; cyc(); conv_done = 0; ack = 0;
    chk("R10 req stays", int'(req), 1);
    chk("R10 no overrun", int'(ovr), 0);
    chk("R10 data", int'(data), 'h66);

    keep = 1;
    conv(16'h0077);
    chk("R3 ovr set", int'(ovr), 1);
    chk("R3 req dropped", int'(req), 0);
    chk("R4 keep old", int'(data), 'h66);
    conv(16'h0088);
    chk("R3 no req while flagged", int'(req), 0);
    chk("R4 keep while flagged", int'(data), 'h66);

    clr = 1; cyc(); clr = 0;
    chk("R5 clear", int'(ovr), 0);
    conv(16'h0099);
    chk("R3 req resumes", int'(req), 1);
    keep = 0;
    conv_done = 1; conv_data = 16'h00AA; clr = 1; cyc(); conv_done = 0; clr = 0;
    chk("R5 set wins over clear", int'(ovr), 1);
    chk("R4 overwrite", int'(data), 'hAA);
    conv(16'h00BB);
    chk("R4 overwrite while flagged", int'(data), 'hBB);
    clr = 1; cyc(); clr = 0;

    conv(16'h00C1); do_ack();
    eot = 1; cyc(); eot = 0;
    chk("R6 abort pulse", int'(abort_o), 1);
    chk("R6 req low", int'(req), 0);
    cyc();
    chk("R6 abort one cycle", int'(abort_o), 0);
    conv(16'h00C2);
    chk("R6 data frozen", int'(data), 'hC1);
    chk("R6 no req", int'(req), 0);
    chk("R6 no overrun", int'(ovr), 0);

    start = 1; cyc(); start = 0;
    conv(16'h00D1);
    chk("R7 start resumes", int'(req), 1);
    chk("R7 data", int'(data), 'hD1);
    do_ack();
    eot = 1; conv_done = 1; conv_data = 16'h00D2; cyc(); eot = 0; conv_done = 0;
    chk("R6 same-cycle abort", int'(abort_o), 1);
    chk("R6 same-cycle sample discarded", int'(data), 'hD1);
    wcfg(0, 0); wcfg(1, 0);
    conv(16'h00D3);
    chk("R7 toggle resumes", int'(req), 1);
    do_ack();

    wcfg(1, 1);
    eot = 1; cyc(); eot = 0;
    chk("R8 no abort", int'(abort_o), 0);
    conv(16'h00E1);
    chk("R8 req continues", int'(req), 1);
    do_ack();

    conv(16'h00E2);
    wcfg(0, 1);
    chk("R11 disable drops req", int'(req), 0);

    for (int i = 0; i < 4000; i++) begin
      conv_done = ($urandom_range(0, 2) == 0);
      conv_data = DW'($urandom);
      conv_busy = ($urandom_range(0, 3) == 0);
      start     = ($urandom_range(0, 30) == 0);
      cfg_we    = ($urandom_range(0, 25) == 0);
      cfg_en    = ($urandom_range(0, 3) != 0);
      cfg_circ  = $urandom_range(0, 1) == 1;
      keep      = $urandom_range(0, 1) == 1;
      clr       = ($urandom_range(0, 12) == 0);
      ack       = req && ($urandom_range(0, 1) == 1);
      eot       = ($urandom_range(0, 20) == 0);
      cyc();
    end
    {conv_done, conv_busy, start, cfg_we, clr, ack, eot} = '0;
    cyc();
    finish_run();
  end
endmodule